// File: doc/BRIEF.md
# Command-Driven Serial Luminance Loader

This block is the data-side front end of a PWM constant-current LED driver. A 3-bit command bus and a serial data line are both sampled on the rising edge of the data clock. Under the shift command, the serial data fills a shift chain of 10-bit grey values for 16 channels. The chain is one LED bank long in single-LED mode and two banks long in dual-LED mode. Its far end is brought out as a cascade output, so several drivers can be daisy-chained.

The command is registered before it is acted on, so every command takes effect on the rising edge after the one that sampled it. A capture command copies the chain into holding latches in one cycle. In single-LED mode it copies bank 0 only. In dual-LED mode it copies both banks. The latched values go out in parallel to the PWM stage. The emit, disable and test commands belong to other stages and leave this block unchanged.

Top module: `lum_loader`

## Requirements
- R1: `cmd_i` is sampled on each rising edge of `clk_i`, and the sampled command acts on the following rising edge. When shift (3'b010) is sampled on edge N, the `sdi_i` value sampled on edge N+1 enters the chain, and the `sdi_i` value on edge N is ignored.
- R2: When the registered command is not shift, the chain keeps its contents.
- R3: In single-LED mode, a frame is 160 bits. The first bit shifted is bit 9 of channel 15. Bits then run from high to low within each channel, channels run from 15 down to 0, and the last bit is bit 0 of channel 0. After capture, channel c of bank 0 appears at `grey_o[10*c +: 10]`.
- R4: In dual-LED mode, a frame is 320 bits. The first 160 bits are bank 1 (LED2), in the R3 order. The last 160 bits are bank 0 (LED1), in the same order. Channel c of bank 1 appears at `grey_o[160 + 10*c +: 10]`.
- R5: `sdo_o` shows the chain bit that entered 160 shifts earlier in single-LED mode and 320 shifts earlier in dual-LED mode.
- R6: `sdo_o` changes only on the falling edge of `clk_i`.
- R7: Capture (3'b011) loads every holding latch of the active banks in a single cycle and leaves the chain unchanged. In single-LED mode, bank 1 keeps its value.
- R8: Command 3'b000 selects single-LED mode and 3'b001 selects dual-LED mode, shown on `dual_o`. Neither command changes the latches or the chain.
- R9: Commands 3'b100, 3'b101, 3'b110 and 3'b111 change no latch, no chain bit and not the mode.
- R10: While `rst_ni` is low, the mode is single-LED, all latches and chain bits are zero and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Command bus |
| sdi_i | input | 1 | Serial grey data in |
| sdo_o | output | 1 | Cascade serial out, updated on falling edge |
| dual_o | output | 1 | 1 when dual-LED mode is selected |
| grey_o | output | 320 | Latched grey values, bank-major, then channel, 10 bits each |

## Verification
The bench loads frames in both modes, using values that are all ones, all zeros and mixed in each channel. It then compares every latched channel with the value that the bit order predicts. A loader that lost the one-cycle command latency, or that reversed the channel or bit order, would put every value in the wrong place. On every cycle `sdo_o` is compared with the bit that entered the chain one chain length earlier. A tap at the wrong length, an update on the rising edge, or a chain that moved during capture or any idle command would break that stream. Capture in single-LED mode is checked to leave bank 1 unchanged, and mode switching is checked to leave the latched data unchanged.

// File: rtl/lum_pkg.sv
package lum_pkg;
  typedef enum logic [2:0] {
    CMD_SINGLE  = 3'b000,
    CMD_DUAL    = 3'b001,
    CMD_SHIFT   = 3'b010,
    CMD_CAPTURE = 3'b011,
    CMD_EMIT1   = 3'b100,
    CMD_EMIT2   = 3'b101,
    CMD_STOP    = 3'b110,
    CMD_TEST    = 3'b111
  } cmd_e;
endpackage

// File: rtl/lum_cmd_dec.sv
module lum_cmd_dec
  import lum_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cmd_i,
  output logic       shift_en_o,
  output logic       capture_en_o,
  output logic       dual_o
);
  cmd_e cmd_q;
  logic dual_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= CMD_STOP;
    else         cmd_q <= cmd_e'(cmd_i);
  end

  // mode follows the registered command, same latency as every other action
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  dual_q <= 1'b0;
    else if (cmd_q == CMD_SINGLE) dual_q <= 1'b0;
    else if (cmd_q == CMD_DUAL)   dual_q <= 1'b1;
  end

  assign shift_en_o   = (cmd_q == CMD_SHIFT);
  assign capture_en_o = (cmd_q == CMD_CAPTURE);
  assign dual_o       = dual_q;
endmodule

// File: rtl/lum_shift_chain.sv
module lum_shift_chain #(
  parameter int unsigned CHAIN_W   = 320,
  parameter int unsigned SHORT_LEN = 160
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               dual_i,
  input  logic               sdi_i,
  output logic [CHAIN_W-1:0] chain_o,
  output logic               sdo_o
);
  logic [CHAIN_W-1:0] chain_q;
  logic               sdo_q;
  logic               tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         chain_q <= '0;
    else if (shift_en_i) chain_q <= {chain_q[CHAIN_W-2:0], sdi_i};
  end

  assign tap = dual_i ? chain_q[CHAIN_W-1] : chain_q[SHORT_LEN-1];

  // cascade output retimed to the falling edge for hold margin downstream
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_q <= 1'b0;
    else         sdo_q <= tap;
  end

  assign chain_o = chain_q;
  assign sdo_o   = sdo_q;
endmodule

// File: rtl/lum_hold_bank.sv
module lum_hold_bank #(
  parameter int unsigned BANK_W = 160
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BANK_W-1:0] d_i,
  output logic [BANK_W-1:0] q_o
);
  logic [BANK_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (load_i) q <= d_i;
  end

  assign q_o = q;
endmodule

// File: rtl/lum_loader.sv
module lum_loader #(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned GREY_W   = 10,
  parameter int unsigned NUM_BANK = 2
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [2:0]                          cmd_i,
  input  logic                                sdi_i,
  output logic                                sdo_o,
  output logic                                dual_o,
  output logic [NUM_BANK*NUM_CH*GREY_W-1:0]   grey_o
);
  localparam int unsigned BANK_W  = NUM_CH * GREY_W;
  localparam int unsigned CHAIN_W = NUM_BANK * BANK_W;

  logic               shift_en;
  logic               capture_en;
  logic               dual;
  logic [CHAIN_W-1:0] chain;

  lum_cmd_dec i_cmd_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_i        (cmd_i),
    .shift_en_o   (shift_en),
    .capture_en_o (capture_en),
    .dual_o       (dual)
  );

  lum_shift_chain #(
    .CHAIN_W   (CHAIN_W),
    .SHORT_LEN (BANK_W)
  ) i_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (shift_en),
    .dual_i     (dual),
    .sdi_i      (sdi_i),
    .chain_o    (chain),
    .sdo_o      (sdo_o)
  );

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic load;
    // bank 0 is active in both modes; upper banks only in dual mode
    if (b == 0) begin : g_base
      assign load = capture_en;
    end else begin : g_upper
      assign load = capture_en & dual;
    end

    lum_hold_bank #(.BANK_W(BANK_W)) i_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .d_i    (chain[b*BANK_W +: BANK_W]),
      .q_o    (grey_o[b*BANK_W +: BANK_W])
    );
  end

  assign dual_o = dual;
endmodule

// File: rtl/lum_loader_chk.sv
module lum_loader_chk #(
  parameter int unsigned NUM_CH   = 16,
  parameter int unsigned GREY_W   = 10,
  parameter int unsigned NUM_BANK = 2
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic [2:0]                        cmd_i,
  input logic                              dual_o,
  input logic [NUM_BANK*NUM_CH*GREY_W-1:0] grey_o
);
  localparam int unsigned BANK_W = NUM_CH * GREY_W;

  // R7: latches move only two edges after a sampled capture
  p_latch_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(grey_o) |-> $past(cmd_i, 2) == 3'b011);

  // R7: upper bank never loads while single mode was active
  p_single_keeps_bank1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(grey_o[2*BANK_W-1:BANK_W]) |-> $past(dual_o));

  // R8: mode moves only after a mode command
  p_mode_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dual_o) |-> ($past(cmd_i, 2) == 3'b000 || $past(cmd_i, 2) == 3'b001));

  // R8: dual command selects dual mode
  p_mode_dual_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_i, 2) == 3'b001 |-> dual_o);

  // R8: single command selects single mode
  p_mode_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cmd_i, 2) == 3'b000 |-> !dual_o);

  // R10: reset state
  p_reset_r10: assert property (@(posedge clk_i)
    !rst_ni |-> (grey_o == '0 && !dual_o));
endmodule

bind lum_loader lum_loader_chk #(
  .NUM_CH   (NUM_CH),
  .GREY_W   (GREY_W),
  .NUM_BANK (NUM_BANK)
) i_lum_loader_chk (.*);

// File: tb/test_lum_loader.sv
module test_lum_loader;
  logic         clk_i  = 1'b0;
  logic         rst_ni = 1'b0;
  logic [2:0]   cmd_i  = 3'b110;
  logic         sdi_i  = 1'b0;
  logic         sdo_o;
  logic         dual_o;
  logic [319:0] grey_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  // bench reference state
  bit         m_chain [320];
  bit         m_dual;
  logic [2:0] m_cmd;
  bit         m_sdo;
  logic [9:0] f [2][16];
  logic [9:0] exp_g [2][16];

  lum_loader i_lum_loader (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd_i),
    .sdi_i  (sdi_i),
    .sdo_o  (sdo_o),
    .dual_o (dual_o),
    .grey_o (grey_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: apply the edge to the reference, drive inputs, verify the cascade pin
  task automatic cyc(input logic [2:0] c, input bit d);
    @(posedge clk_i);
    if (m_cmd == 3'b010) begin
      for (int i = 319; i > 0; i--) m_chain[i] = m_chain[i-1];
      m_chain[0] = sdi_i;
    end else if (m_cmd == 3'b000) m_dual = 0;
    else if (m_cmd == 3'b001) m_dual = 1;
    m_cmd = cmd_i;
    #1;
    check("R6 sdo stable at rising edge", sdo_o, m_sdo);
    cmd_i = c;
    sdi_i = d;
    @(negedge clk_i);
    #1;
    m_sdo = m_dual ? m_chain[319] : m_chain[159];
    check("R5 R1 R2 cascade stream", sdo_o, m_sdo);
  endtask

  function automatic bit frame_bit(input int k, input bit dual);
    int bank, j;
    if (dual) begin
      bank = (k < 160) ? 1 : 0;
      j    = k % 160;
    end else begin
      bank = 0;
      j    = k;
    end
    return f[bank][15 - j/10][9 - j%10];
  endfunction

  task automatic load(input bit dual);
    int n = dual ? 320 : 160;
    cyc(3'b010, 1'b1);  // lead bit must be ignored (R1)
    for (int k = 0; k < n; k++) cyc((k < n-1) ? 3'b010 : 3'b110, frame_bit(k, dual));
    cyc(3'b110, 1'b0);
  endtask

  task automatic capture();
    cyc(3'b011, 1'b1);
    cyc(3'b110, 1'b0);
    cyc(3'b110, 1'b0);
  endtask

  task automatic check_grey(input string req);
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 16; c++)
        check(req, grey_o[(b*16+c)*10 +: 10], exp_g[b][c]);
  endtask

  task automatic fill(input int seed);
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 16; c++)
        f[b][c] = 10'((c * 37 + b * 101 + seed * 211) ^ (seed * 5));
    f[0][15] = 10'h3ff; f[0][0] = 10'h000;
    f[1][15] = 10'h000; f[1][0] = 10'h3ff;
  endtask

  initial begin
    for (int i = 0; i < 320; i++) m_chain[i] = 0;
    m_dual = 0; m_cmd = 3'b110; m_sdo = 0;
    for (int b = 0; b < 2; b++) for (int c = 0; c < 16; c++) exp_g[b][c] = '0;

    #21;
    check("R10 reset latches", grey_o == '0, 1);
    check("R10 reset mode", dual_o, 0);
    check("R10 reset sdo", sdo_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // single-LED frame
    fill(1);
    load(0);
    capture();
    for (int c = 0; c < 16; c++) exp_g[0][c] = f[0][c];
    check_grey("R3 R7 single capture");

    // non-data commands touch nothing
    for (int k = 0; k < 3; k++) begin
      cyc(3'b100, 1'b1); cyc(3'b101, 1'b0); cyc(3'b111, 1'b1); cyc(3'b110, 1'b1);
    end
    check_grey("R9 emit/stop/test no effect");
    check("R9 mode kept", dual_o, 0);

    // dual-LED frame
    cyc(3'b001, 1'b0); cyc(3'b110, 1'b0); cyc(3'b110, 1'b0);
    check("R8 dual selected", dual_o, 1);
    check_grey("R8 mode switch keeps latches");
    fill(2);
    load(1);
    capture();
    for (int c = 0; c < 16; c++) begin exp_g[0][c] = f[0][c]; exp_g[1][c] = f[1][c]; end
    check_grey("R4 R7 dual capture");

    // back to single: bank 1 must survive a capture
    cyc(3'b000, 1'b0); cyc(3'b110, 1'b0); cyc(3'b110, 1'b0);
    check("R8 single selected", dual_o, 0);
    check_grey("R8 mode switch keeps latches");
    fill(3);
    load(0);
    capture();
    for (int c = 0; c < 16; c++) exp_g[0][c] = f[0][c];
    check_grey("R7 single capture keeps bank1");

    // repeated capture without shifting: chain unchanged
    capture();
    check_grey("R7 capture leaves chain intact");
    fill(4);
    load(0);
    capture();
    for (int c = 0; c < 16; c++) exp_g[0][c] = f[0][c];
    check_grey("R3 second single frame");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule